// File: doc/BRIEF.md
# Program Counter with Immediate Branch and Jump Resolution

This block holds the program counter of a simple 32-bit load/store core that has no branch delay slots. Each cycle in which the step enable is high, it takes the opcode and function fields and the two source register values of the current instruction. It then moves the counter to one of three places: the next sequential word, a PC-relative branch target, or an absolute jump target. The instruction after a taken branch or jump is never executed, because the new counter value takes effect on the very next step.

For the two linking jumps, the block also supplies the return address, the destination register number and a write strobe, which an external register file consumes. The return address is always derived from the counter as it was before the step, so it does not matter whether the link register is also the jump source. Every candidate target is checked for word alignment and against a parameterised memory window. An illegal target stops the unit: the counter freezes and a sticky fault flag rises, and both stay that way until reset.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `pc` is 0x00001000, `fault` is 0 and `link_we` is 0.
- R2: A step with an instruction that is not a branch or jump moves `pc` to `pc`+4. A cycle with `step_en` low leaves `pc` unchanged.
- R3: Opcode 0x04 (branch if equal): when `rs_val` equals `rt_val`, the next `pc` is `pc`+4 plus the sign-extended 16-bit `branch_off` times 4. Otherwise the next `pc` is `pc`+4.
- R4: Opcode 0x05 (branch if not equal) uses the same target as R3 but is taken when `rs_val` differs from `rt_val`.
- R5: Opcode 0x02 (jump) sets the next `pc` to bits 31:28 of `pc`+4, followed by the 26-bit `jump_index`, followed by two zero bits.
- R6: Opcode 0x03 (jump and link) goes to the same target as R5. During that step it drives `link_we`=1, `link_dest`=31 and `link_val`=`pc`+4.
- R7: Opcode 0x00 with function 0x08 (register jump) sets the next `pc` to `rs_val`.
- R8: Opcode 0x00 with function 0x09 (register jump and link) sets the next `pc` to `rs_val`. During that step it drives `link_we`=1, `link_dest`=`rd_idx` and `link_val`=`pc`+4, whatever the value of `rs_val`.
- R9: A target is illegal when its low two bits are not zero, when it is zero, or when it is not below MEM_SIZE (default 0x00100000). A stepped instruction with an illegal target sets `fault`, leaves `pc` unchanged and keeps `link_we` at 0.
- R10: While `fault` is 1, `step_en` has no effect: `pc` holds, `link_we` stays 0 and `fault` stays 1 until reset.
- R11: Opcode 0x00 with any function code other than 0x08 or 0x09 advances sequentially, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Execute the presented instruction this cycle |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field, used when opcode is 0 |
| rd_idx | input | 5 | Destination register for register jump and link |
| jump_index | input | 26 | Absolute jump word index |
| branch_off | input | 16 | Signed branch word offset |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc | output | 32 | Current program counter |
| link_val | output | 32 | Return address to be written |
| link_dest | output | 5 | Register number for the return address |
| link_we | output | 1 | Return address write strobe |
| fault | output | 1 | Sticky illegal-target flag |

## Verification
The hardest situations to reach from the ports are an illegal target exactly at the top of the memory window, and the frozen state after a fault. To reach the first, the stimulus uses a legal register jump to the last word below MEM_SIZE and then a plain sequential step, which steps one word past the end. Linking jumps are then issued while the unit is frozen, so the bench can confirm that no link write escapes and that the counter does not move. Separate resets open runs that fault on a misaligned address, on address zero and on a jump index beyond the window.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned IDX_W  = 26;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned INSN_BYTES = 4;
  localparam logic [REG_W-1:0] LINK_REG = REG_W'(31);

  localparam logic [OPC_W-1:0] OPC_REGOP = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JLNK  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE   = 6'h05;
  localparam logic [OPC_W-1:0] FN_JREG   = 6'h08;
  localparam logic [OPC_W-1:0] FN_JRLNK  = 6'h09;

  typedef enum logic [2:0] {
    FLOW_SEQ, FLOW_BEQ, FLOW_BNE, FLOW_JMP, FLOW_JLNK, FLOW_JREG, FLOW_JRLNK
  } flow_e;

  typedef struct packed {
    flow_e kind;
    logic  links;
  } flow_ctl_t;

  function automatic logic [ADDR_W-1:0] seq_pc(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(INSN_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] cur,
                                                   input logic [OFF_W-1:0]  off);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return seq_pc(cur) + ext;
  endfunction

  function automatic logic [ADDR_W-1:0] abs_target(input logic [ADDR_W-1:0] cur,
                                                   input logic [IDX_W-1:0]  idx);
    logic [ADDR_W-1:0] nxt;
    nxt = seq_pc(cur);
    return {nxt[ADDR_W-1:IDX_W+2], idx, 2'b00};
  endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [OPC_W-1:0] funct,
  output flow_ctl_t        ctl
);
  always_comb begin
    ctl.kind  = FLOW_SEQ;
    ctl.links = 1'b0;
    unique case (opcode)
      OPC_JMP:  ctl.kind = FLOW_JMP;
      OPC_JLNK: begin ctl.kind = FLOW_JLNK; ctl.links = 1'b1; end
      OPC_BEQ:  ctl.kind = FLOW_BEQ;
      OPC_BNE:  ctl.kind = FLOW_BNE;
      OPC_REGOP: begin
        if (funct == FN_JREG) ctl.kind = FLOW_JREG;
        else if (funct == FN_JRLNK) begin
          ctl.kind  = FLOW_JRLNK;
          ctl.links = 1'b1;
        end
      end
      default: ctl.kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_pc,
  input  flow_e             kind,
  input  logic [OFF_W-1:0]  branch_off,
  input  logic [IDX_W-1:0]  jump_index,
  input  logic [ADDR_W-1:0] rs_val,
  input  logic [ADDR_W-1:0] rt_val,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              redirect
);
  logic [ADDR_W-1:0] fall_thru;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] jmp_tgt;
  logic              operands_eq;
  logic              br_taken;

  assign fall_thru   = seq_pc(cur_pc);
  assign br_tgt      = rel_target(cur_pc, branch_off);
  assign jmp_tgt     = abs_target(cur_pc, jump_index);
  assign operands_eq = (rs_val == rt_val);
  assign ret_addr    = fall_thru;

  always_comb begin
    br_taken = 1'b0;
    next_pc  = fall_thru;
    unique case (kind)
      FLOW_BEQ:   begin br_taken = operands_eq;  if (operands_eq)  next_pc = br_tgt; end
      FLOW_BNE:   begin br_taken = !operands_eq; if (!operands_eq) next_pc = br_tgt; end
      FLOW_JMP,
      FLOW_JLNK:  next_pc = jmp_tgt;
      FLOW_JREG,
      FLOW_JRLNK: next_pc = rs_val;
      default:    next_pc = fall_thru;
    endcase
  end

  assign redirect = br_taken || (kind inside {FLOW_JMP, FLOW_JLNK, FLOW_JREG, FLOW_JRLNK});
endmodule

// File: rtl/npc_guard.sv
module npc_guard
  import npc_pkg::*;
#(
  parameter int unsigned MEM_SIZE = 32'h0010_0000
)(
  input  logic [ADDR_W-1:0] addr,
  output logic              legal
);
  localparam int unsigned SIZE_LOG2 = $clog2(MEM_SIZE);
  localparam bit          SIZE_POW2 = ((MEM_SIZE & (MEM_SIZE - 1)) == 0) && (SIZE_LOG2 > 2);

  logic misaligned;
  logic is_null;
  logic beyond_top;

  assign misaligned = |addr[1:0];
  assign is_null    = (addr == '0);

  generate
    if (SIZE_POW2) begin : g_pow2
      assign beyond_top = |addr[ADDR_W-1:SIZE_LOG2];
    end else begin : g_cmp
      assign beyond_top = (addr >= ADDR_W'(MEM_SIZE));
    end
  endgenerate

  assign legal = !(misaligned || is_null || beyond_top);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import npc_pkg::*;
#(
  parameter int unsigned MEM_SIZE = 32'h0010_0000,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_en,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  input  logic [4:0]  rd_idx,
  input  logic [25:0] jump_index,
  input  logic [15:0] branch_off,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] link_val,
  output logic [4:0]  link_dest,
  output logic        link_we,
  output logic        fault
);
  logic [ADDR_W-1:0] pc_q;
  logic              fault_q;
  flow_ctl_t         ctl;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] ret_addr;
  logic              redirect;
  logic              tgt_legal;
  logic              advance;
  logic              commit;
  logic              trap;

  npc_decode u_dec (.opcode(opcode), .funct(funct), .ctl(ctl));

  npc_select u_sel (
    .cur_pc(pc_q), .kind(ctl.kind), .branch_off(branch_off),
    .jump_index(jump_index), .rs_val(rs_val), .rt_val(rt_val),
    .next_pc(next_pc), .ret_addr(ret_addr), .redirect(redirect)
  );

  npc_guard #(.MEM_SIZE(MEM_SIZE)) u_grd (.addr(next_pc), .legal(tgt_legal));

  assign advance = step_en && !fault_q;
  assign commit  = advance && tgt_legal;
  assign trap    = advance && !tgt_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      fault_q <= 1'b0;
    end else if (commit) begin
      pc_q    <= next_pc;
    end else if (trap) begin
      fault_q <= 1'b1;
    end
  end

  assign pc        = pc_q;
  assign fault     = fault_q;
  assign link_val  = ret_addr;
  assign link_dest = (ctl.kind == FLOW_JLNK) ? LINK_REG : rd_idx;
  assign link_we   = commit && ctl.links;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !redirect && tgt_legal) |=> (pc == $past(pc) + 32'd4));

  a_r6_link_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (link_we && opcode == OPC_JLNK) |-> (link_dest == 5'd31 && link_val == pc + 32'd4));

  a_r7_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && opcode == OPC_REGOP && funct == FN_JREG && tgt_legal) |=> (pc == $past(rs_val)));

  a_r9_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  a_r9_trap_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (fault && $stable(pc)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && $stable(pc) && !link_we));

endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  localparam int unsigned MEM = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [4:0]  rd_idx = '0;
  logic [25:0] jump_index = '0;
  logic [15:0] branch_off = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc, link_val;
  logic [4:0]  link_dest;
  logic        link_we, fault;

  pc_sequencer #(.MEM_SIZE(MEM)) u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .opcode(opcode), .funct(funct),
    .rd_idx(rd_idx), .jump_index(jump_index), .branch_off(branch_off),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .link_val(link_val),
    .link_dest(link_dest), .link_we(link_we), .fault(fault)
  );

  always #5 clk = ~clk;

  typedef struct { logic [31:0] pc; logic flt; string tag; } exp_t;
  exp_t sb[$];

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_pc = 32'h0000_1000;
  logic        m_flt = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: compare state produced by the previous edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "pc", pc, e.pc);
      chk(e.tag, "fault", {31'b0, fault}, {31'b0, e.flt});
    end
  end

  function automatic bit legal(input logic [31:0] a);
    return (a % 4 == 0) && (a != 0) && (a < MEM);
  endfunction

  task automatic issue(input string tag, input bit en, input logic [5:0] op, input logic [5:0] fn,
                       input logic [4:0] rd, input logic [25:0] idx, input logic [15:0] off,
                       input logic [31:0] rs, input logic [31:0] rt);
    logic [31:0] p4, tgt;
    int soff;
    bit lnk, ok, expwe;
    exp_t e;
    @(negedge clk);
    step_en = en; opcode = op; funct = fn; rd_idx = rd; jump_index = idx;
    branch_off = off; rs_val = rs; rt_val = rt;
    #1;
    p4   = m_pc + 32'd4;
    soff = $signed(off);
    lnk  = 1'b0;
    tgt  = p4;
    if (op == 6'h02 || op == 6'h03) begin
      tgt = (p4 & 32'hF000_0000) | (32'(idx) * 4);
      lnk = (op == 6'h03);
    end else if (op == 6'h04) begin
      if (rs == rt) tgt = p4 + 32'(soff * 4);
    end else if (op == 6'h05) begin
      if (rs != rt) tgt = p4 + 32'(soff * 4);
    end else if (op == 6'h00 && (fn == 6'h08 || fn == 6'h09)) begin
      tgt = rs;
      lnk = (fn == 6'h09);
    end
    ok    = legal(tgt);
    expwe = en && !m_flt && lnk && ok;
    chk(tag, "link_we", {31'b0, link_we}, {31'b0, expwe});
    if (expwe) begin
      chk(tag, "link_val", link_val, p4);
      chk(tag, "link_dest", {27'b0, link_dest}, (op == 6'h03) ? 32'd31 : {27'b0, rd});
    end
    if (en && !m_flt) begin
      if (ok) m_pc = tgt;
      else    m_flt = 1'b1;
    end
    e.pc = m_pc; e.flt = m_flt; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    @(negedge clk);
    step_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = 32'h0000_1000;
    m_flt = 1'b0;
    #1;
    chk("R1", "pc", pc, 32'h0000_1000);
    chk("R1", "fault", {31'b0, fault}, 32'd0);
    chk("R1", "link_we", {31'b0, link_we}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    issue("R11", 1, 6'h00, 6'h21, 0, 0, 0, 1, 2);
    issue("R2",  1, 6'h23, 6'h00, 0, 0, 0, 0, 0);
    issue("R2",  0, 6'h02, 6'h00, 0, 26'h800, 0, 0, 0);
    issue("R3",  1, 6'h04, 0, 0, 0, 16'd4, 7, 7);
    issue("R3",  1, 6'h04, 0, 0, 0, 16'd4, 1, 2);
    issue("R3",  1, 6'h04, 0, 0, 0, 16'hFFFE, 9, 9);
    issue("R4",  1, 6'h05, 0, 0, 0, 16'd3, 1, 2);
    issue("R4",  1, 6'h05, 0, 0, 0, 16'd3, 5, 5);
    issue("R5",  1, 6'h02, 0, 0, 26'h800, 0, 0, 0);
    issue("R6",  1, 6'h03, 0, 0, 26'h900, 0, 0, 0);
    issue("R7",  1, 6'h00, 6'h08, 0, 0, 0, 32'h3000, 0);
    issue("R8",  1, 6'h00, 6'h09, 5'd5, 0, 0, 32'h1500, 0);
    issue("R11", 1, 6'h00, 6'h00, 0, 0, 0, 0, 0);
    issue("R9",  1, 6'h00, 6'h08, 0, 0, 0, 32'h1502, 0);
    issue("R10", 1, 6'h03, 0, 0, 26'h900, 0, 0, 0);
    issue("R10", 1, 6'h00, 6'h09, 5'd4, 0, 0, 32'h2000, 0);
    issue("R10", 1, 6'h00, 6'h21, 0, 0, 0, 0, 0);
    do_reset();
    issue("R9",  1, 6'h00, 6'h09, 5'd7, 0, 0, 32'h0, 0);
    issue("R10", 1, 6'h02, 0, 0, 26'h800, 0, 0, 0);
    do_reset();
    issue("R9",  1, 6'h02, 0, 0, 26'h3FF_FFFF, 0, 0, 0);
    do_reset();
    issue("R7",  1, 6'h00, 6'h08, 0, 0, 0, MEM - 32'd4, 0);
    issue("R9",  1, 6'h00, 6'h25, 0, 0, 0, 0, 0);
    issue("R10", 1, 6'h00, 6'h08, 0, 0, 0, 32'h1000, 0);
    @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule